// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds four 40-bit counters, reached through a 64-bit register interface with a one-cycle response. One shared control word picks what each counter counts: clock cycles, one of four single-cycle event pulse inputs, or nothing. The same word carries a global run bit and a clear command that zeroes every counter at once.

Software can load any counter directly. Loading 2^40 minus P makes the counter roll over after P counted events, so the bank can act as a periodic timer. A rollover sets a sticky flag for that counter, and the OR of all flags drives a level interrupt. Only the clear command drops the flags. Loading a counter again leaves its flag set.

Top module: `evc_bank`

## Requirements
- R1: After a synchronous active-low reset, all counters and the control word read as zero, `irq` is low and `rsp_valid` is low.
- R2: Address 0 is the control word. Bits [4k+3:4k] hold the source code of counter k, and bit 33 is the run bit. A write stores only these bits. A read returns them with every other bit zero, including the clear bit 34. The word can be updated by read-modify-write without disturbing other counters' fields.
- R3: Source code 1 makes a counter add one on every clock edge at which the run bit is set. Source code 0 holds the counter constant.
- R4: Source codes 2 to 5 count the cycles in which `ev_pulse[code-2]` is high. Source codes 6 to 15 count nothing.
- R5: While the run bit is clear, no counter changes except by load or clear. A change to the run bit takes effect at the edge after the write that sets it.
- R6: A write to address k+1 loads counter k with `req_wdata[39:0]` at that edge. A read of address k+1 returns the counter zero-extended to 64 bits.
- R7: A counter at 2^40-1 that counts again wraps to 0 and sets its overflow flag. `irq` is high from that edge on. A counter loaded with 2^40-P overflows on its P-th counted event.
- R8: Once set, `irq` stays high through loads and any number of cycles, until a clear.
- R9: A control write with bit 34 set zeroes all counters and all overflow flags at that edge, ahead of any count or load. The clear bit is not stored.
- R10: Every accepted request gets `rsp_valid` exactly one cycle later. Write responses carry zero data. Reads of unmapped addresses (5 to 7) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | 0 = control word, 1..4 = counters 0..3 |
| req_wdata | input | 64 | Write data |
| ev_pulse | input | 4 | Single-cycle event pulses |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 64 | Read data, zero for writes |
| irq | output | 1 | Level overflow interrupt request |

## Verification
The checker watches the response protocol, zero write data, zero-extension of counter reads, the clear bit reading back as zero, the stickiness of `irq` and its drop after a clear. These hold on every cycle. Count accuracy per source, the exact rollover edge for a loaded value, the timing of the run bit and the priority of clear over counting depend on stimulus history. A behavioural model in the bench covers these, and directed scenarios check each one against hand-computed values.

// File: rtl/evc_pkg.sv
// Package for the event counter bank.
// Holds the control-word bit positions and the source codes shared by RTL and checker.
package evc_pkg;
    localparam int EVC_RUN_BIT     = 33;
    localparam int EVC_CLR_BIT     = 34;
    localparam int EVC_SRC_NONE    = 0;
    localparam int EVC_SRC_CYCLE   = 1;
    localparam int EVC_SRC_EV_BASE = 2;
endpackage

// File: rtl/evc_cfg_reg.sv
// Control word register.
// Stores the per-counter source fields and the run bit.
// Turns the clear bit of a write into a one-cycle pulse and does not store it.
// Assumes NUM_CTR*SRC_W stays below the run bit position.
module evc_cfg_reg
    import evc_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SRC_W   = 4,
    parameter int DATA_W  = 64,
    localparam int FLD_W  = NUM_CTR * SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [FLD_W-1:0]  src_flat,
    output logic              run,
    output logic              clr_pulse,
    output logic [DATA_W-1:0] cfg_view
);
    logic [FLD_W-1:0] fld_q;
    logic             run_q;

    // Capture the source fields and the run bit on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
            run_q <= 1'b0;
        end else if (wr_en) begin
            fld_q <= wdata[FLD_W-1:0];
            run_q <= wdata[EVC_RUN_BIT];
        end
    end

    // Clear acts in the write cycle only.
    assign clr_pulse = wr_en & wdata[EVC_CLR_BIT];
    assign src_flat  = fld_q;
    assign run       = run_q;

    // Readback image: stored bits only.
    always_comb begin
        cfg_view              = '0;
        cfg_view[FLD_W-1:0]   = fld_q;
        cfg_view[EVC_RUN_BIT] = run_q;
    end
endmodule

// File: rtl/evc_counter.sv
// One counter slice.
// Picks its increment from the source code, adds one and wraps.
// Holds a sticky overflow flag.
// Priority: clear, then load, then count.
module evc_counter
    import evc_pkg::*;
#(
    parameter int CTR_W  = 40,
    parameter int SRC_W  = 4,
    parameter int NUM_EV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              load,
    input  logic [CTR_W-1:0]  load_val,
    input  logic              run,
    input  logic [SRC_W-1:0]  src,
    input  logic [NUM_EV-1:0] ev,
    output logic [CTR_W-1:0]  cnt,
    output logic              ovf
);
    logic             hit;
    logic [CTR_W:0]   sum;
    logic [CTR_W-1:0] cnt_q;
    logic             ovf_q;

    // Decode the source code into an increment request for this cycle.
    always_comb begin
        hit = (src == SRC_W'(EVC_SRC_CYCLE));
        for (int i = 0; i < NUM_EV; i++) begin
            if (src == SRC_W'(EVC_SRC_EV_BASE + i)) hit = ev[i];
        end
    end

    assign sum = {1'b0, cnt_q} + {{CTR_W{1'b0}}, 1'b1};

    // Update the count and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && hit) begin
            cnt_q <= sum[CTR_W-1:0];
            if (sum[CTR_W]) ovf_q <= 1'b1;
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/evc_bank.sv
// Event counter bank, top level.
// Decodes register requests, instantiates the counters, muxes readback
// and registers a one-cycle response.
// Address 0 is the control word; addresses 1..NUM_CTR are the counters.
module evc_bank
    import evc_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 40,
    parameter int DATA_W  = 64,
    parameter int NUM_EV  = 4,
    parameter int SRC_W   = 4,
    localparam int ADDR_W = $clog2(NUM_CTR + 1),
    localparam int FLD_W  = NUM_CTR * SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NUM_EV-1:0] ev_pulse,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq
);
    logic              cfg_wr;
    logic [FLD_W-1:0]  src_flat;
    logic              run;
    logic              clr_pulse;
    logic [DATA_W-1:0] cfg_view;
    logic [CTR_W-1:0]  cnt_w [NUM_CTR];
    logic [NUM_CTR-1:0] ovf_w;
    logic [DATA_W-1:0] rd_val;
    logic              rsp_v_q;
    logic [DATA_W-1:0] rsp_d_q;

    assign cfg_wr = req_valid & req_write & (req_addr == '0);

    evc_cfg_reg #(.NUM_CTR(NUM_CTR), .SRC_W(SRC_W), .DATA_W(DATA_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wdata     (req_wdata),
        .src_flat  (src_flat),
        .run       (run),
        .clr_pulse (clr_pulse),
        .cfg_view  (cfg_view)
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        logic ld;
        assign ld = req_valid & req_write & (req_addr == ADDR_W'(k + 1));
        evc_counter #(.CTR_W(CTR_W), .SRC_W(SRC_W), .NUM_EV(NUM_EV)) ctr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_all  (clr_pulse),
            .load     (ld),
            .load_val (req_wdata[CTR_W-1:0]),
            .run      (run),
            .src      (src_flat[k*SRC_W +: SRC_W]),
            .ev       (ev_pulse),
            .cnt      (cnt_w[k]),
            .ovf      (ovf_w[k])
        );
    end

    // Readback mux; unmapped addresses give zero.
    always_comb begin
        rd_val = '0;
        if (req_addr == '0) rd_val = cfg_view;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (req_addr == ADDR_W'(k + 1)) rd_val = {{(DATA_W-CTR_W){1'b0}}, cnt_w[k]};
        end
    end

    // One-cycle response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            rsp_v_q <= req_valid;
            rsp_d_q <= (req_valid && !req_write) ? rd_val : '0;
        end
    end

    assign rsp_valid = rsp_v_q;
    assign rsp_rdata = rsp_d_q;
    assign irq       = |ovf_w;
endmodule

// File: rtl/evc_bank_chk.sv
// Protocol and interrupt checker for evc_bank, attached by bind.
// Sees only the ports of the top module.
module evc_bank_chk
    import evc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 3,
    parameter int CTR_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq
);
    logic clr_wr;
    assign clr_wr = req_valid && req_write && (req_addr == '0) && req_wdata[EVC_CLR_BIT];

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10
    wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));
    // R6
    ctr_read_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr != '0) |=> (rsp_rdata[DATA_W-1:CTR_W] == '0));
    // R2
    clr_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == '0) |=> !rsp_rdata[EVC_CLR_BIT]);
    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);
    // R9
    clr_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !irq);
endmodule

bind evc_bank evc_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTR_W(CTR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq)
);

// File: tb/evc_bank_tb_top.sv
`timescale 1ns/1ps
// Bench for evc_bank: a behavioural model compared on every cycle, plus directed scenarios.
module evc_bank_tb_top;
    localparam logic [63:0] CMASK = 64'h0000_00FF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [3:0]  ev_pulse = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evc_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ev_pulse(ev_pulse),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    // Behavioural reference model
    longint unsigned m_cnt [4];
    bit              m_flag [4];
    bit [63:0]       m_cfg = '0;
    bit              m_rv = 0;
    bit [63:0]       m_rd = '0;
    bit              m_irq = 0;
    bit [63:0]       m_tmp;
    bit              m_clr, m_en, m_hit;
    int              m_src;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[k]) begin m_cnt[k] = 0; m_flag[k] = 0; end
            m_cfg = '0; m_rv = 0; m_rd = '0; m_irq = 0;
        end else begin
            m_tmp = '0;
            if (req_valid && !req_write) begin
                if (req_addr == 0) m_tmp = m_cfg;
                else if (req_addr <= 4) m_tmp = m_cnt[req_addr-1];
            end
            m_rv = req_valid;
            m_rd = m_tmp;
            m_en = m_cfg[33];
            m_clr = req_valid && req_write && req_addr == 0 && req_wdata[34];
            for (int k = 0; k < 4; k++) begin
                m_src = int'((m_cfg >> (4*k)) & 64'hF);
                m_hit = (m_src == 1) || (m_src >= 2 && m_src <= 5 && ev_pulse[m_src-2]);
                if (m_clr) begin
                    m_cnt[k] = 0; m_flag[k] = 0;
                end else if (req_valid && req_write && req_addr == 3'(k+1)) begin
                    m_cnt[k] = req_wdata & CMASK;
                end else if (m_en && m_hit) begin
                    if (m_cnt[k] == CMASK) begin m_cnt[k] = 0; m_flag[k] = 1; end
                    else m_cnt[k] = m_cnt[k] + 1;
                end
            end
            if (req_valid && req_write && req_addr == 0) m_cfg = req_wdata & 64'h0000_0002_0000_FFFF;
            m_irq = m_flag[0] | m_flag[1] | m_flag[2] | m_flag[3];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq === m_irq, "R7 irq vs model", 64'(irq), 64'(m_irq));
            chk(rsp_valid === m_rv, "R10 rsp_valid vs model", 64'(rsp_valid), 64'(m_rv));
            if (m_rv) chk(rsp_rdata === m_rd, "R10 rsp_rdata vs model", rsp_rdata, m_rd);
        end
    end

    function automatic logic [63:0] cw(int s0, int s1, int s2, int s3, bit en, bit clr);
        return 64'(s0) | (64'(s1) << 4) | (64'(s2) << 8) | (64'(s3) << 12)
             | (64'(en) << 33) | (64'(clr) << 34);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0;
        chk(rsp_valid === 1'b1 && rsp_rdata === 64'h0, "R10 write response", rsp_rdata, 64'h0);
    endtask

    task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string tag);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        chk(rsp_valid === 1'b1 && rsp_rdata === exp, tag, rsp_rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] e);
        ev_pulse = e;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(irq === 1'b0, "R1 irq after reset", 64'(irq), 0);
        chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);
        rd(0, 0, "R1 control word reset");
        rd(3, 0, "R1 counter2 reset");
        // R6 load and zero-extended read
        wr(2, 64'hFFFF_FF12_3456_789A);
        rd(2, 64'h0000_0012_3456_789A, "R6 load counter1");
        // R3 cycle counting: run edge E0, disable write at E7 still counts
        wr(0, cw(1, 0, 0, 0, 1, 0));
        repeat (6) @(negedge clk);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        rd(1, 7, "R3 counter0 counted cycles");
        rd(2, 64'h12_3456_789A, "R3 source 0 holds value");
        // R5 stopped
        repeat (5) @(negedge clk);
        rd(1, 7, "R5 no count while run bit clear");
        // R2 stored bits only, read-modify-write
        wr(0, cw(1, 0, 2, 0, 0, 0) | (64'h1 << 50));
        rd(0, 64'h201, "R2 control readback masks");
        req_valid = 1; req_write = 0; req_addr = 0;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        v = rsp_rdata | (64'h5 << 12);
        wr(0, v);
        rd(0, 64'h5201, "R2 read-modify-write keeps fields");
        // R4 event sources
        wr(0, cw(0, 12, 2, 5, 1, 0));
        repeat (3) pulse(4'b0001);
        repeat (2) pulse(4'b1000);
        repeat (4) pulse(4'b0010);
        pulse(4'b1001);
        wr(0, cw(0, 12, 2, 5, 0, 0));
        rd(3, 4, "R4 counter2 on ev_pulse[0]");
        rd(4, 3, "R4 counter3 on ev_pulse[3]");
        rd(2, 64'h12_3456_789A, "R4 code 12 counts nothing");
        rd(1, 7, "R4 code 0 counts nothing");
        // R7 overflow after P=3 counted cycles
        wr(1, (64'h1 << 40) - 3);
        wr(0, cw(1, 0, 0, 0, 1, 0));
        repeat (2) @(negedge clk);
        chk(irq === 1'b0, "R7 no irq before rollover", 64'(irq), 0);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        chk(irq === 1'b1, "R7 irq on rollover", 64'(irq), 1);
        rd(1, 0, "R7 counter wraps to zero");
        // R8 sticky through load
        wr(1, 5);
        chk(irq === 1'b1, "R8 irq survives load", 64'(irq), 1);
        repeat (3) @(negedge clk);
        chk(irq === 1'b1, "R8 irq holds", 64'(irq), 1);
        rd(1, 5, "R8 load after overflow");
        // R9 clear
        wr(0, cw(1, 0, 0, 0, 1, 1));
        chk(irq === 1'b0, "R9 clear drops irq", 64'(irq), 0);
        repeat (3) @(negedge clk);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        rd(1, 4, "R9 counting from zero after clear");
        rd(2, 0, "R9 clear zeroes counter1");
        rd(0, 64'h1, "R2 clear bit not stored");
        wr(0, cw(1, 0, 0, 0, 1, 0));
        repeat (3) @(negedge clk);
        wr(0, cw(1, 0, 0, 0, 1, 1));
        wr(0, cw(1, 0, 0, 0, 0, 0));
        rd(1, 1, "R9 clear beats count");
        // R10 unmapped read
        rd(7, 0, "R10 unmapped address reads zero");
        rd(5, 0, "R10 address 5 reads zero");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule